// File: doc/BRIEF.md
# Snooping MSI Cache Controller

This block is the cache controller for one processor on a shared snooping bus. The cache is direct-mapped and write-back, and it keeps coherence by invalidation. Each line holds a coherence state (Invalid, Shared or Modified), a tag and a block of two 32-bit words. The processor side issues one read or write at a time. When the line cannot serve the access locally, the controller requests the bus with a single request/grant pair and issues a read-miss, write-miss or write-back transaction. The bench's memory model returns fill data one or more cycles after a miss is granted.

The controller also watches the transactions of the other caches every cycle. A snooped read miss that hits a Modified line makes this cache supply the block. The memory model must then take the block as a write-back and drop its own reply. A snooped write miss invalidates a matching line, and a Modified line also supplies its data.

The processor state machine has five states:
- `FS_IDLE` accepts requests and completes hits.
- `FS_WRBACK` evicts a dirty victim.
- `FS_MISS` holds the bus request for the miss.
- `FS_FILL` waits for the block.
- `FS_RESP` gives the one-cycle completion.

Its transitions are:
- accept-hit: IDLE to RESP.
- accept-dirty-victim: IDLE to WRBACK.
- accept-miss: IDLE to MISS.
- victim-done: WRBACK to MISS, on grant, or at once if the victim is no longer dirty.
- miss-granted: MISS to FILL.
- fill: FILL to RESP.
- complete: RESP to IDLE.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_busy`, `bus_req` and `snp_supply` are low.
- R2: A processor read that misses drives `bus_cmd` = 1 (read miss) with the block address. It completes after `bus_rvalid` and returns the selected word. The line ends Shared, so later reads of either word complete with no bus request.
- R3: A processor write to a line that is Shared or Invalid for its tag drives `bus_cmd` = 2 (write miss). The written word is merged into the returned block, and the line ends Modified. Word select 0 is bits [31:0] of a block and word select 1 is bits [63:32].
- R4: Reads and writes that hit a Modified line complete with no bus request. A write updates only the selected word.
- R5: A miss whose line is Modified under a different tag first issues `bus_cmd` = 3 (write-back) with the old block address and data. The miss request follows in the cycle after that grant.
- R6: A snooped read miss (`snp_cmd` = 1) that matches a Modified line raises `snp_supply` in the next cycle. The pulse carries the block address and data. The line becomes Shared.
- R7: A snooped write miss (`snp_cmd` = 2) that matches a Modified line supplies the block the same way and makes the line Invalid. One that matches a Shared line makes it Invalid with no supply.
- R8: A snoop whose tag differs from the stored tag, or whose line is Invalid, changes nothing and supplies nothing.
- R9: `cpu_busy` is high from the cycle after a request is accepted until completion, including while the grant is withheld. `cpu_done` is a one-cycle pulse.
- R10: A snoop and a processor request to the same line index in the same cycle are resolved snoop first. The processor access is held one cycle and then acts on the post-snoop state.
- R11: The line index is the low log2(LINES) bits of the block address and the tag is the rest. Two blocks that differ only in the tag share a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | BLK_AW | Block address |
| cpu_wsel | input | 1 | Word select within the block |
| cpu_wdata | input | WORD_W | Write data |
| cpu_busy | output | 1 | Request in progress |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | WORD_W | Read data, valid with `cpu_done` on reads |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; a transaction completes in a cycle with `bus_req` and `bus_gnt` |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | BLK_AW | Transaction block address |
| bus_wdata | output | 2*WORD_W | Write-back data |
| bus_rvalid | input | 1 | Fill data valid |
| bus_rdata | input | 2*WORD_W | Fill data |
| snp_valid | input | 1 | Snooped transaction valid |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | BLK_AW | Snooped block address |
| snp_supply | output | 1 | This cache supplies the block; memory writes it and skips its reply |
| snp_sup_addr | output | BLK_AW | Supplied block address |
| snp_sup_data | output | 2*WORD_W | Supplied block data |

## Verification
A snooped transaction and a processor access can target the same line in one cycle. The case that matters is a write that would hit a Modified line while another cache's read miss for the same block arrives. The bench drives both on the same falling edge.

The correct result is this sequence:
1. A supply of the old block data.
2. A write-miss transaction, because the line is by then Shared.
3. The completion.

Any other order, or a silent local write, shows in the scoreboard as a mismatch. Separate snoops on Modified, Shared and non-matching lines are each followed by a processor access. Whether that access hits or misses reveals the state the snoop left.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WRBACK = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/1ps
module msi_line_store
    import msi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TAG_W = 6,
    parameter int BLK_W = 64,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    // full-line write from the processor side
    input  logic             f_we,
    input  logic [IDX_W-1:0] f_idx,
    input  line_st_t         f_st,
    input  logic [TAG_W-1:0] f_tag,
    input  logic [BLK_W-1:0] f_data,
    // state-only write from the snoop side
    input  logic             s_we,
    input  logic [IDX_W-1:0] s_idx,
    input  line_st_t         s_st,
    // read port 0 (processor)
    input  logic [IDX_W-1:0] r0_idx,
    output line_st_t         r0_st,
    output logic [TAG_W-1:0] r0_tag,
    output logic [BLK_W-1:0] r0_data,
    // read port 1 (snoop)
    input  logic [IDX_W-1:0] r1_idx,
    output line_st_t         r1_st,
    output logic [TAG_W-1:0] r1_tag,
    output logic [BLK_W-1:0] r1_data
);
    line_st_t         st_q   [LINES];
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [BLK_W-1:0] data_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i] <= ST_I;
            end else if (f_we && f_idx == IDX_W'(i)) begin
                st_q[i] <= f_st;
            end else if (s_we && s_idx == IDX_W'(i)) begin
                st_q[i] <= s_st;
            end
        end

        always_ff @(posedge clk) begin
            if (f_we && f_idx == IDX_W'(i)) begin
                tag_q[i]  <= f_tag;
                data_q[i] <= f_data;
            end
        end
    end

    assign r0_st   = st_q[r0_idx];
    assign r0_tag  = tag_q[r0_idx];
    assign r0_data = data_q[r0_idx];
    assign r1_st   = st_q[r1_idx];
    assign r1_tag  = tag_q[r1_idx];
    assign r1_data = data_q[r1_idx];

    AST_SNOOP_NEVER_DIRTIES: assert property (@(posedge clk) disable iff (!rst_n)
        s_we |-> (s_st != ST_M)); // R7
endmodule

// File: rtl/msi_snoop_unit.sv
`timescale 1ns/1ps
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int BLK_AW = 8,
    parameter int LINES  = 4,
    parameter int BLK_W  = 64,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = BLK_AW - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [BLK_AW-1:0] snp_addr,
    input  logic [BLK_AW-1:0] cpu_addr,
    // line lookup
    output logic [IDX_W-1:0]  lk_idx,
    input  line_st_t          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [BLK_W-1:0]  ln_data,
    // state update
    output logic              s_we,
    output logic [IDX_W-1:0]  s_idx,
    output line_st_t          s_st,
    // same-line collision with the processor side
    output logic              snp_conflict,
    // supply of dirty data
    output logic              snp_supply,
    output logic [BLK_AW-1:0] snp_sup_addr,
    output logic [BLK_W-1:0]  snp_sup_data
);
    logic     tag_match;
    logic     flush;
    bus_cmd_t cmd;

    assign cmd          = bus_cmd_t'(snp_cmd);
    assign lk_idx       = snp_addr[IDX_W-1:0];
    assign s_idx        = snp_addr[IDX_W-1:0];
    assign tag_match    = snp_valid && (ln_st != ST_I) && (ln_tag == snp_addr[BLK_AW-1:IDX_W]);
    assign snp_conflict = snp_valid && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);

    always_comb begin
        s_we  = 1'b0;
        s_st  = ln_st;
        flush = 1'b0;
        unique case (cmd)
            BC_RDMISS: begin
                if (tag_match && ln_st == ST_M) begin
                    s_we  = 1'b1;
                    s_st  = ST_S;
                    flush = 1'b1;
                end
            end
            BC_WRMISS: begin
                if (tag_match) begin
                    s_we  = 1'b1;
                    s_st  = ST_I;
                    flush = (ln_st == ST_M);
                end
            end
            default: begin
                s_we  = 1'b0;
                flush = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snp_supply   <= 1'b0;
            snp_sup_addr <= '0;
            snp_sup_data <= '0;
        end else begin
            snp_supply <= flush;
            if (flush) begin
                snp_sup_addr <= snp_addr;
                snp_sup_data <= ln_data;
            end
        end
    end

    AST_SUPPLY_FOLLOWS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> $past(snp_valid)); // R6
endmodule

// File: rtl/msi_cpu_fsm.sv
`timescale 1ns/1ps
module msi_cpu_fsm
    import msi_pkg::*;
#(
    parameter int BLK_AW = 8,
    parameter int LINES  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = BLK_AW - IDX_W,
    localparam int BLK_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [BLK_AW-1:0] cpu_addr,
    input  logic              cpu_wsel,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              snp_conflict,
    // line lookup
    output logic [IDX_W-1:0]  rd_idx,
    input  line_st_t          ln_st,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [BLK_W-1:0]  ln_data,
    // line write
    output logic              f_we,
    output logic [IDX_W-1:0]  f_idx,
    output line_st_t          f_st,
    output logic [TAG_W-1:0]  f_tag,
    output logic [BLK_W-1:0]  f_data,
    // bus master side
    output logic              bus_req,
    input  logic              bus_gnt,
    output bus_cmd_t          bus_cmd,
    output logic [BLK_AW-1:0] bus_addr,
    output logic [BLK_W-1:0]  bus_wdata,
    input  logic              bus_rvalid,
    input  logic [BLK_W-1:0]  bus_rdata,
    // processor handshake
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [WORD_W-1:0] cpu_rdata
);
    typedef enum logic [2:0] {
        FS_IDLE   = 3'd0,
        FS_WRBACK = 3'd1,
        FS_MISS   = 3'd2,
        FS_FILL   = 3'd3,
        FS_RESP   = 3'd4
    } fsm_t;

    fsm_t              st_q, st_nx;
    logic              r_we, r_wsel;
    logic [BLK_AW-1:0] r_addr;
    logic [WORD_W-1:0] r_wdata;
    logic [WORD_W-1:0] rdata_q;

    logic accept, tag_hit, rd_hit, wr_hit, need_wb;

    function automatic logic [BLK_W-1:0] merge_word(input logic [BLK_W-1:0] blk,
                                                    input logic sel,
                                                    input logic [WORD_W-1:0] w);
        logic [BLK_W-1:0] o;
        o = blk;
        if (sel) o[BLK_W-1:WORD_W] = w;
        else     o[WORD_W-1:0]     = w;
        return o;
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] blk,
                                                    input logic sel);
        return sel ? blk[BLK_W-1:WORD_W] : blk[WORD_W-1:0];
    endfunction

    assign rd_idx  = (st_q == FS_IDLE) ? cpu_addr[IDX_W-1:0] : r_addr[IDX_W-1:0];
    assign accept  = (st_q == FS_IDLE) && cpu_req && !snp_conflict;
    assign tag_hit = (ln_st != ST_I) && (ln_tag == cpu_addr[BLK_AW-1:IDX_W]);
    assign rd_hit  = !cpu_we && tag_hit;
    assign wr_hit  = cpu_we && tag_hit && (ln_st == ST_M);
    assign need_wb = (ln_st == ST_M) && (ln_tag != r_addr[BLK_AW-1:IDX_W]);

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= FS_IDLE;
            r_we    <= 1'b0;
            r_wsel  <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
            rdata_q <= '0;
        end else begin
            st_q <= st_nx;
            if (accept) begin
                r_we    <= cpu_we;
                r_wsel  <= cpu_wsel;
                r_addr  <= cpu_addr;
                r_wdata <= cpu_wdata;
                if (rd_hit) rdata_q <= pick_word(ln_data, cpu_wsel);
            end
            if (st_q == FS_FILL && bus_rvalid && !r_we)
                rdata_q <= pick_word(bus_rdata, r_wsel);
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FS_IDLE: begin
                if (accept) begin
                    if (rd_hit || wr_hit)   st_nx = FS_RESP;
                    else if (ln_st == ST_M) st_nx = FS_WRBACK;
                    else                    st_nx = FS_MISS;
                end
            end
            FS_WRBACK: if (!need_wb || bus_gnt) st_nx = FS_MISS;
            FS_MISS:   if (bus_gnt)             st_nx = FS_FILL;
            FS_FILL:   if (bus_rvalid)          st_nx = FS_RESP;
            FS_RESP:                            st_nx = FS_IDLE;
            default:                            st_nx = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = r_addr;
        bus_wdata = ln_data;
        f_we      = 1'b0;
        f_idx     = r_addr[IDX_W-1:0];
        f_st      = ST_S;
        f_tag     = r_addr[BLK_AW-1:IDX_W];
        f_data    = bus_rdata;
        cpu_done  = 1'b0;
        unique case (st_q)
            FS_IDLE: begin
                if (accept && wr_hit) begin
                    f_we   = 1'b1;
                    f_idx  = cpu_addr[IDX_W-1:0];
                    f_st   = ST_M;
                    f_tag  = cpu_addr[BLK_AW-1:IDX_W];
                    f_data = merge_word(ln_data, cpu_wsel, cpu_wdata);
                end
            end
            FS_WRBACK: begin
                bus_req  = need_wb;
                bus_cmd  = need_wb ? BC_WRBACK : BC_NONE;
                bus_addr = {ln_tag, r_addr[IDX_W-1:0]};
            end
            FS_MISS: begin
                bus_req = 1'b1;
                bus_cmd = r_we ? BC_WRMISS : BC_RDMISS;
            end
            FS_FILL: begin
                if (bus_rvalid) begin
                    f_we   = 1'b1;
                    f_st   = r_we ? ST_M : ST_S;
                    f_data = r_we ? merge_word(bus_rdata, r_wsel, r_wdata) : bus_rdata;
                end
            end
            FS_RESP: cpu_done = 1'b1;
            default: cpu_done = 1'b0;
        endcase
    end

    assign cpu_busy  = (st_q != FS_IDLE);
    assign cpu_rdata = rdata_q;

    AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == BC_WRBACK) |=> (bus_req && bus_cmd != BC_WRBACK)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R9
    AST_STALL_ON_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_busy && snp_conflict) |=> !cpu_done); // R10
    AST_FILL_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == BC_WRMISS) |-> cpu_busy); // R3
endmodule

// File: rtl/msi_cache_ctrl.sv
`timescale 1ns/1ps
module msi_cache_ctrl
    import msi_pkg::*;
#(
    parameter int BLK_AW = 8,
    parameter int LINES  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = BLK_AW - IDX_W,
    localparam int BLK_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [BLK_AW-1:0] cpu_addr,
    input  logic              cpu_wsel,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [BLK_AW-1:0] bus_addr,
    output logic [BLK_W-1:0]  bus_wdata,
    input  logic              bus_rvalid,
    input  logic [BLK_W-1:0]  bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [BLK_AW-1:0] snp_addr,
    output logic              snp_supply,
    output logic [BLK_AW-1:0] snp_sup_addr,
    output logic [BLK_W-1:0]  snp_sup_data
);
    logic [IDX_W-1:0] p_idx, q_idx, f_idx, s_idx;
    line_st_t         p_st, q_st, f_st, s_st;
    logic [TAG_W-1:0] p_tag, q_tag, f_tag;
    logic [BLK_W-1:0] p_data, q_data, f_data;
    logic             f_we, s_we, conflict;
    bus_cmd_t         cmd_e;

    assign bus_cmd = cmd_e;

    msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .f_we(f_we), .f_idx(f_idx), .f_st(f_st), .f_tag(f_tag), .f_data(f_data),
        .s_we(s_we), .s_idx(s_idx), .s_st(s_st),
        .r0_idx(p_idx), .r0_st(p_st), .r0_tag(p_tag), .r0_data(p_data),
        .r1_idx(q_idx), .r1_st(q_st), .r1_tag(q_tag), .r1_data(q_data)
    );

    msi_snoop_unit #(.BLK_AW(BLK_AW), .LINES(LINES), .BLK_W(BLK_W)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .cpu_addr(cpu_addr),
        .lk_idx(q_idx), .ln_st(q_st), .ln_tag(q_tag), .ln_data(q_data),
        .s_we(s_we), .s_idx(s_idx), .s_st(s_st),
        .snp_conflict(conflict),
        .snp_supply(snp_supply), .snp_sup_addr(snp_sup_addr), .snp_sup_data(snp_sup_data)
    );

    msi_cpu_fsm #(.BLK_AW(BLK_AW), .LINES(LINES), .WORD_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wsel(cpu_wsel),
        .cpu_wdata(cpu_wdata), .snp_conflict(conflict),
        .rd_idx(p_idx), .ln_st(p_st), .ln_tag(p_tag), .ln_data(p_data),
        .f_we(f_we), .f_idx(f_idx), .f_st(f_st), .f_tag(f_tag), .f_data(f_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(cmd_e), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata)
    );

    AST_NO_SUPPLY_ON_OWN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_supply && bus_req) |-> (bus_addr != snp_sup_addr || bus_cmd != 2'd1)); // R6
endmodule

// File: tb/sim_msi_cache_ctrl.sv
`timescale 1ns/1ps
module sim_msi_cache_ctrl;
    localparam int K_RD = 1, K_WR = 2, K_WB = 3, K_SUP = 4, K_DONE = 5;

    typedef struct {
        int          kind;
        logic [7:0]  addr;
        logic [63:0] data;
        bit          chk;
        string       rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_wsel = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_busy, cpu_done;
    logic [31:0] cpu_rdata;
    logic        bus_req, bus_gnt, bus_rvalid;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [63:0] bus_wdata, bus_rdata;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic        snp_supply;
    logic [7:0]  snp_sup_addr;
    logic [63:0] snp_sup_data;
    logic        gnt_en = 1'b1;

    int    n_cmp = 0, n_bad = 0;
    exp_t  q[$];
    logic [63:0] gold [256];
    logic [63:0] mem  [256];
    int          pend_cnt;
    logic [7:0]  pend_addr;

    always #2.5 clk = ~clk;
    assign bus_gnt = bus_req & gnt_en;

    msi_cache_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wsel(cpu_wsel),
        .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_supply(snp_supply), .snp_sup_addr(snp_sup_addr), .snp_sup_data(snp_sup_data)
    );

    function automatic logic [63:0] blk_init(input int a);
        return {(32'(a) * 32'h0101_0101) ^ 32'hA5A5_0000, 32'(a) + 32'h0000_1000};
    endfunction

    function automatic logic [31:0] word_of(input logic [63:0] b, input logic s);
        return s ? b[63:32] : b[31:0];
    endfunction

    // memory model: write-backs, supplies, delayed fill replies
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= blk_init(i);
            pend_cnt   <= 0;
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= 1'b0;
            if (pend_cnt != 0) begin
                pend_cnt <= pend_cnt - 1;
                if (pend_cnt == 1) begin
                    bus_rvalid <= 1'b1;
                    bus_rdata  <= mem[pend_addr];
                end
            end
            if (bus_req && bus_gnt) begin
                if (bus_cmd == 2'd3) mem[bus_addr] <= bus_wdata;
                else begin
                    pend_cnt  <= 2;
                    pend_addr <= bus_addr;
                end
            end
            if (snp_supply) mem[snp_sup_addr] <= snp_sup_data;
        end
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
        end
    endtask

    task automatic compare_ev(input int kind, input logic [7:0] a, input logic [63:0] d);
        exp_t e;
        bit   ok;
        if (q.size() == 0) begin
            check(1'b0, "R4", $sformatf("unexpected event kind %0d addr %h", kind, a), d, '0);
        end else begin
            e  = q.pop_front();
            ok = (e.kind == kind) && (kind == K_DONE || e.addr == a) && (!e.chk || e.data == d);
            check(ok, e.rq, $sformatf("event kind %0d/%0d addr %h/%h", kind, e.kind, a, e.addr),
                  d, e.data);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (snp_supply)         compare_ev(K_SUP, snp_sup_addr, snp_sup_data);
            if (bus_req && bus_gnt) compare_ev(int'(bus_cmd), bus_addr, bus_wdata);
            if (cpu_done)           compare_ev(K_DONE, 8'h00, {32'h0, cpu_rdata});
        end
    end

    task automatic expect_ev(input int kind, input logic [7:0] a, input logic [63:0] d,
                             input bit chk, input string rq);
        exp_t e;
        e.kind = kind; e.addr = a; e.data = d; e.chk = chk; e.rq = rq;
        q.push_back(e);
    endtask

    task automatic cpu_op(input logic we, input logic [7:0] a, input logic s,
                          input logic [31:0] wd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wsel = s; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_done);
        cpu_req = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic s, input string rq);
        expect_ev(K_DONE, 8'h00, {32'h0, word_of(gold[a], s)}, 1'b1, rq);
        cpu_op(1'b0, a, s, 32'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic s, input logic [31:0] wd, input string rq);
        expect_ev(K_DONE, 8'h00, 64'h0, 1'b0, rq);
        cpu_op(1'b1, a, s, wd);
        if (s) gold[a][63:32] = wd;
        else   gold[a][31:0]  = wd;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", '0, '0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) gold[i] = blk_init(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cpu_busy == 1'b0, "R1", "busy after reset", 64'(cpu_busy), 64'h0);
        check(bus_req == 1'b0, "R1", "bus_req after reset", 64'(bus_req), 64'h0);
        check(snp_supply == 1'b0, "R1", "supply after reset", 64'(snp_supply), 64'h0);

        // R2 read miss then read hits on Shared
        expect_ev(K_RD, 8'h10, '0, 1'b0, "R2");
        rd(8'h10, 1'b0, "R2");
        rd(8'h10, 1'b1, "R2");
        // R3 upgrade write from Shared
        expect_ev(K_WR, 8'h10, '0, 1'b0, "R3");
        wr(8'h10, 1'b0, 32'hDEAD_0001, "R3");
        // R4 hits on Modified
        wr(8'h10, 1'b1, 32'hBEEF_0002, "R4");
        rd(8'h10, 1'b0, "R4");
        rd(8'h10, 1'b1, "R4");
        // R5 and R11: same index, other tag, dirty victim
        expect_ev(K_WB, 8'h10, gold[8'h10], 1'b1, "R5");
        expect_ev(K_WR, 8'h14, '0, 1'b0, "R11");
        wr(8'h14, 1'b1, 32'hC0DE_0003, "R5");
        rd(8'h14, 1'b0, "R3");
        // R6 snooped read miss on Modified
        expect_ev(K_SUP, 8'h14, gold[8'h14], 1'b1, "R6");
        snoop(2'd1, 8'h14);
        rd(8'h14, 1'b1, "R6");
        expect_ev(K_WR, 8'h14, '0, 1'b0, "R6");
        wr(8'h14, 1'b0, 32'h1111_0004, "R6");
        // R7 snooped write miss on Modified
        expect_ev(K_SUP, 8'h14, gold[8'h14], 1'b1, "R7");
        snoop(2'd2, 8'h14);
        expect_ev(K_RD, 8'h14, '0, 1'b0, "R7");
        rd(8'h14, 1'b0, "R7");
        // R7 snooped write miss on Shared
        snoop(2'd2, 8'h14);
        expect_ev(K_RD, 8'h14, '0, 1'b0, "R7");
        rd(8'h14, 1'b1, "R7");
        // R8 snoops with a different tag
        expect_ev(K_WR, 8'h14, '0, 1'b0, "R8");
        wr(8'h14, 1'b0, 32'h2222_0005, "R8");
        snoop(2'd2, 8'h18);
        snoop(2'd1, 8'h18);
        wr(8'h14, 1'b1, 32'h3333_0006, "R8");
        rd(8'h14, 1'b0, "R8");
        // R9 grant withheld
        expect_ev(K_RD, 8'h21, '0, 1'b0, "R9");
        gnt_en = 1'b0;
        fork
            rd(8'h21, 1'b1, "R9");
            begin
                repeat (6) @(negedge clk);
                check(cpu_busy == 1'b1, "R9", "busy while grant withheld", 64'(cpu_busy), 64'h1);
                gnt_en = 1'b1;
            end
        join
        @(negedge clk);
        check(cpu_busy == 1'b0, "R9", "busy after completion", 64'(cpu_busy), 64'h0);
        // R10 snoop and processor write to the same line in one cycle
        expect_ev(K_SUP, 8'h14, gold[8'h14], 1'b1, "R10");
        expect_ev(K_WR, 8'h14, '0, 1'b0, "R10");
        fork
            snoop(2'd1, 8'h14);
            wr(8'h14, 1'b0, 32'h4444_0007, "R10");
        join
        rd(8'h14, 1'b0, "R10");
        // R5 with a read miss
        expect_ev(K_WB, 8'h14, gold[8'h14], 1'b1, "R5");
        expect_ev(K_RD, 8'h1C, '0, 1'b0, "R5");
        rd(8'h1C, 1'b1, "R5");

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R4", "leftover expected events", 64'(q.size()), 64'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule